// File: doc/BRIEF.md
# Single-Precision Reciprocal Estimate Unit

This unit takes one 32-bit IEEE-754 single-precision operand and returns an approximation of its reciprocal that is accurate to about 8 bits. Such a value usually seeds a Newton-Raphson division sequence. The mantissa comes from a small exactly-defined integer reciprocal kernel. The unit does no refinement. Exponent handling covers subnormal operands and subnormal results. Special values, tiny operands and huge operands follow fixed rules, and those rules depend on the flush-to-zero, default-NaN and rounding-mode controls that come in alongside the operand.

The operand and its controls are sampled on a clock edge when `in_valid` is high. The result and five exception flags are registered and appear one cycle later, with `out_valid` set. No operation is ever held back, so the unit accepts one operand per cycle. When `in_valid` is low the outputs keep their last values.

Top module: `rcp_est_unit`

## Requirements
- R1: The result and flags are registered. An operand sampled with `in_valid` high appears on `result`/`exc_flags` one clock later with `out_valid` high. A cycle with `in_valid` low gives `out_valid` low on the next cycle and leaves `result` and `exc_flags` unchanged.
- R2: For a normal finite operand with biased exponent e, the kernel input is a = 256 + (top 8 fraction bits). The kernel value is est = (floor(2^19 / (2a+1)) + 1) >> 1, which always lies in 256..511. The result is {sign, 253−e, est[7:0], 15 zero bits}, and all flags are 0.
- R3: A subnormal operand, with flush disabled and magnitude at least 2^-128, is normalised before the kernel runs. If fraction bit 22 is 1, the fraction is shifted left by 1 and e is taken as 0. Otherwise it is shifted left by 2 and e is taken as −1. Bits shifted past bit 22 are dropped.
- R4: When 253−e equals 0, the result exponent field is 0 and the fraction is {1, est[7:0], 14 zeros}. When it equals −1, the exponent field is 0 and the fraction is {0, 1, est[7:0], 13 zeros}. No flag is raised in either case.
- R5: A NaN operand (exponent 255, fraction non-zero) returns the operand with fraction bit 22 forced to 1, sign kept. The invalid flag is raised when bit 22 of the input was 0, which marks a signaling NaN.
- R6: When `dn` is 1, any NaN operand returns 0x7FC00000. Invalid is still raised for a signaling NaN.
- R7: An infinite operand returns a zero of the same sign and raises no flag.
- R8: A zero operand returns an infinity of the same sign and raises divide-by-zero.
- R9: An operand magnitude below 2^-128 (exponent 0, fraction bits 22:21 both 0, fraction non-zero) raises overflow and inexact. `rmode` encodes 0 = nearest, 1 = toward +inf, 2 = toward −inf, 3 = toward zero. The result is a signed infinity under nearest, or under the directed mode that points toward the operand's sign. Otherwise it is the signed largest normal value, magnitude 0x7F7FFFFF.
- R10: With `fz` = 1, a finite operand with exponent 253 or 254 returns a zero of the same sign and raises underflow.
- R11: With `fz` = 1, a subnormal operand is treated as a zero of the same sign. It returns a signed infinity and raises divide-by-zero.
- R12: After reset `out_valid`, `result` and `exc_flags` are all 0. The flag bit order is [4] invalid, [3] divide-by-zero, [2] overflow, [1] underflow, [0] inexact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand and controls are sampled this cycle |
| operand | input | 32 | Single-precision operand |
| fz | input | 1 | Flush-to-zero control |
| dn | input | 1 | Default-NaN control |
| rmode | input | 2 | Rounding mode: 0 nearest, 1 up, 2 down, 3 toward zero |
| out_valid | output | 1 | Result and flags hold a new operation |
| result | output | 32 | Reciprocal estimate |
| exc_flags | output | 5 | {invalid, divzero, overflow, underflow, inexact} |

## Verification
The directed cases aim at the exponent boundaries.

| Corner case | What a wrong design would do |
|---|---|
| Exponents 253 and 254 with flush off | Mishandle the subnormal result: misplace the explicit leading bit, or wrap the exponent to 255 and return a NaN. |
| Exponents 253 and 254 with flush on | Return an estimate instead of a signed zero with underflow. |
| Subnormal operands on both sides of fraction bit 22 | A normaliser that shifts by the wrong amount gives an exponent off by one. |
| Operands just below and just above the 2^-128 threshold | A wrong comparison sends tiny values into the kernel. |
| The tiny cases under all four rounding modes, with both signs | Saturate to the wrong value, infinity instead of the largest normal or the reverse. |
| Quiet and signaling NaNs, with and without default-NaN | A sign dropped, a missing quiet bit or a missed invalid flag. |

Seeded random operands then cover the kernel's whole 256..511 input range against a bench model that finds the quotient by search.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0,
    RM_UP      = 2'd1,
    RM_DOWN    = 2'd2,
    RM_ZERO    = 2'd3
  } rmode_e;

  typedef enum logic [2:0] {
    CL_NAN,
    CL_INF,
    CL_ZERO,
    CL_TINY,
    CL_HUGE_FZ,
    CL_FINITE
  } opclass_e;

  typedef struct packed {
    logic invalid;
    logic divzero;
    logic overflow;
    logic underflow;
    logic inexact;
  } flags_t;

endpackage

// File: rtl/rcp_classify.sv
module rcp_classify
  import rcp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] op,
  input  logic                  fz,
  output opclass_e              cls,
  output logic                  is_snan,
  output logic                  flushed
);
  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam int HUGE_EXP = 2 * BIAS - 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_max, exp_min, frac_nz, tiny_mag;

  assign exp_f    = op[FRAC_W +: EXP_W];
  assign frac_f   = op[FRAC_W-1:0];
  assign exp_max  = &exp_f;
  assign exp_min  = ~|exp_f;
  assign frac_nz  = |frac_f;
  assign tiny_mag = ~|frac_f[FRAC_W-1 -: 2];
  assign flushed  = fz & exp_min & frac_nz;
  assign is_snan  = exp_max & frac_nz & ~frac_f[FRAC_W-1];

  always_comb begin
    if (exp_max)                                   cls = frac_nz ? CL_NAN : CL_INF;
    else if (exp_min && (!frac_nz || fz))          cls = CL_ZERO;
    else if (exp_min && tiny_mag)                  cls = CL_TINY;
    else if (fz && (int'(exp_f) >= HUGE_EXP))      cls = CL_HUGE_FZ;
    else                                           cls = CL_FINITE;
  end
endmodule

// File: rtl/rcp_norm.sv
module rcp_norm #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int CORE_W = 9
) (
  input  logic [EXP_W-1:0]        exp_f,
  input  logic [FRAC_W-1:0]       frac_f,
  output logic signed [EXP_W+1:0] exp_adj,
  output logic [CORE_W-1:0]       core_in
);
  logic [FRAC_W-1:0] frac_n;

  always_comb begin
    if (exp_f != '0) begin
      exp_adj = $signed({2'b00, exp_f});
      frac_n  = frac_f;
    end else if (frac_f[FRAC_W-1]) begin
      exp_adj = '0;
      frac_n  = frac_f << 1;
    end else begin
      exp_adj = '1;
      frac_n  = frac_f << 2;
    end
  end

  assign core_in = {1'b1, frac_n[FRAC_W-1 -: CORE_W-1]};
endmodule

// File: rtl/rcp_core.sv
module rcp_core #(
  parameter int CORE_W = 9
) (
  input  logic [CORE_W-1:0] a,
  output logic [CORE_W-1:0] est
);
  localparam int NUM_W = 2 * CORE_W + 2;
  localparam logic [NUM_W-1:0] NUM = NUM_W'(1) << (2 * CORE_W + 1);

  function automatic logic [CORE_W-1:0] recip_fn(input logic [CORE_W-1:0] x);
    logic [NUM_W-1:0] odd_den;
    logic [NUM_W-1:0] quo;
    logic [NUM_W-1:0] rnd;
    odd_den = NUM_W'({x, 1'b1});
    quo     = NUM / odd_den;
    rnd     = (quo + NUM_W'(1)) >> 1;
    return rnd[CORE_W-1:0];
  endfunction

  assign est = recip_fn(a);
endmodule

// File: rtl/rcp_pack.sv
module rcp_pack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int CORE_W = 9
) (
  input  logic signed [EXP_W+1:0] exp_adj,
  input  logic [CORE_W-1:0]       est,
  output logic [EXP_W-1:0]        res_exp,
  output logic [FRAC_W-1:0]       res_frac,
  output logic                    sub_out
);
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int RES_OFF = 2 * BIAS - 1;

  logic signed [EXP_W+1:0] rexp;
  logic [CORE_W-2:0]       est_lo;

  assign rexp   = (EXP_W+2)'(RES_OFF) - exp_adj;
  assign est_lo = est[CORE_W-2:0];

  always_comb begin
    sub_out = 1'b1;
    res_exp = '0;
    if (rexp == '0) begin
      res_frac = FRAC_W'({1'b1, est_lo}) << (FRAC_W - CORE_W);
    end else if (rexp == '1) begin
      res_frac = FRAC_W'({2'b01, est_lo}) << (FRAC_W - CORE_W - 1);
    end else begin
      sub_out  = 1'b0;
      res_exp  = rexp[EXP_W-1:0];
      res_frac = FRAC_W'(est_lo) << (FRAC_W - CORE_W + 1);
    end
  end
endmodule

// File: rtl/rcp_est_unit.sv
module rcp_est_unit
  import rcp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int CORE_W = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [EXP_W+FRAC_W:0] operand,
  input  logic                  fz,
  input  logic                  dn,
  input  logic [1:0]            rmode,
  output logic                  out_valid,
  output logic [EXP_W+FRAC_W:0] result,
  output logic [4:0]            exc_flags
);
  localparam int W       = EXP_W + FRAC_W + 1;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int RES_OFF = 2 * BIAS - 1;
  localparam logic [W-1:0] DEF_NAN   = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-1:0] QUIET_BIT = W'(1) << (FRAC_W - 1);

  opclass_e                cls;
  logic                    is_snan, flushed;
  logic                    sgn;
  logic signed [EXP_W+1:0] exp_adj;
  logic [CORE_W-1:0]       core_in, core_est;
  logic [EXP_W-1:0]        pk_exp;
  logic [FRAC_W-1:0]       pk_frac;
  logic                    pk_sub;
  logic                    sat_inf;
  logic [W-1:0]            nxt_res;
  flags_t                  nxt_flg;

  assign sgn = operand[W-1];

  rcp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
    .op(operand), .fz(fz), .cls(cls), .is_snan(is_snan), .flushed(flushed)
  );

  rcp_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .CORE_W(CORE_W)) u_norm (
    .exp_f(operand[FRAC_W +: EXP_W]), .frac_f(operand[FRAC_W-1:0]),
    .exp_adj(exp_adj), .core_in(core_in)
  );

  rcp_core #(.CORE_W(CORE_W)) u_core (.a(core_in), .est(core_est));

  rcp_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .CORE_W(CORE_W)) u_pack (
    .exp_adj(exp_adj), .est(core_est),
    .res_exp(pk_exp), .res_frac(pk_frac), .sub_out(pk_sub)
  );

  assign sat_inf = (rmode == RM_NEAREST) ||
                   (rmode == RM_UP   && !sgn) ||
                   (rmode == RM_DOWN &&  sgn);

  always_comb begin
    nxt_flg = '0;
    nxt_res = '0;
    unique case (cls)
      CL_NAN: begin
        nxt_flg.invalid = is_snan;
        nxt_res = dn ? DEF_NAN : (operand | QUIET_BIT);
      end
      CL_INF:  nxt_res = {sgn, {(W-1){1'b0}}};
      CL_ZERO: begin
        nxt_flg.divzero = 1'b1;
        nxt_res = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end
      CL_TINY: begin
        nxt_flg.overflow = 1'b1;
        nxt_flg.inexact  = 1'b1;
        nxt_res = sat_inf ? {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                          : {sgn, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
      end
      CL_HUGE_FZ: begin
        nxt_flg.underflow = 1'b1;
        nxt_res = {sgn, {(W-1){1'b0}}};
      end
      default: nxt_res = {sgn, pk_exp, pk_frac};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      exc_flags <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= nxt_res;
        exc_flags <= nxt_flg;
      end
    end
  end

  // Assertions next to the logic they guard
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(in_valid)));
  p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(exc_flags)));
  p_core_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls == CL_FINITE) |-> core_est[CORE_W-1]);
  p_sub_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls == CL_FINITE && pk_sub) |-> (int'(operand[FRAC_W +: EXP_W]) >= RES_OFF));
  p_nan_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls == CL_NAN) |=> ((&result[FRAC_W +: EXP_W]) && result[FRAC_W-1]));
  p_inf_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls == CL_INF) |=> (result[W-2:0] == '0 && exc_flags == '0));
  p_zero_dz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls == CL_ZERO) |=> (exc_flags[3] && (&result[FRAC_W +: EXP_W])));
  p_no_overflow_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_flags[2] |-> exc_flags[0]);
  p_uf_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && exc_flags[1]) |-> (result[W-2:0] == '0));
  p_flush_dz_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && flushed) |=> exc_flags[3]);
  p_one_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(exc_flags[4:1]));
endmodule

// File: tb/rcp_est_unit_bench.sv
module rcp_est_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] operand = '0;
  logic        fz = 1'b0, dn = 1'b0;
  logic [1:0]  rmode = 2'd0;
  logic        out_valid;
  logic [31:0] result;
  logic [4:0]  exc_flags;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10ns clk = ~clk;

  rcp_est_unit u_rcp_est_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
    .fz(fz), .dn(dn), .rmode(rmode),
    .out_valid(out_valid), .result(result), .exc_flags(exc_flags)
  );

  // Largest b with b*(2a+1) <= 2^19, found by counting up
  function automatic int slow_recip(input int a);
    int den = 2 * a + 1;
    int b = 500;
    while ((b + 1) * den <= 524288) b++;
    return (b + 1) / 2;
  endfunction

  function automatic logic [36:0] model(input logic [31:0] x, input bit f, input bit d,
                                        input logic [1:0] rm);
    bit s = x[31];
    int e = int'(x[30:23]);
    int fr = int'(x[22:0]);
    logic [4:0]  fl = '0;
    logic [31:0] r;
    if (e == 255 && fr != 0) begin
      fl[4] = !x[22];
      r = d ? 32'h7FC00000 : (x | 32'h00400000);
    end else if (e == 255) begin
      r = {s, 31'h0};
    end else if (e == 0 && (fr == 0 || f)) begin
      fl[3] = 1; r = {s, 8'hFF, 23'h0};
    end else if (x[30:0] < 31'h00200000) begin
      fl[2] = 1; fl[0] = 1;
      if (rm == 0 || (rm == 1 && !s) || (rm == 2 && s)) r = {s, 8'hFF, 23'h0};
      else r = {s, 31'h7F7FFFFF};
    end else if (f && e >= 253) begin
      fl[1] = 1; r = {s, 31'h0};
    end else begin
      int m, ee, est, rx;
      if (e != 0) begin m = fr; ee = e; end
      else if (fr >= 32'h400000) begin m = (fr * 2) % 32'h800000; ee = 0; end
      else begin m = (fr * 4) % 32'h800000; ee = -1; end
      est = slow_recip(256 + m / 32768);
      rx = 253 - ee;
      if (rx > 0)       r = {s, rx[7:0], est[7:0], 15'h0};
      else if (rx == 0) r = {s, 8'h0, 1'b1, est[7:0], 14'h0};
      else              r = {s, 8'h0, 2'b01, est[7:0], 13'h0};
    end
    return {fl, r};
  endfunction

  function automatic string tag_of(input logic [31:0] x, input bit f, input bit d);
    int e = int'(x[30:23]);
    if (e == 255 && x[22:0] != 0) return d ? "R6" : "R5";
    if (e == 255) return "R7";
    if (e == 0 && x[22:0] == 0) return "R8";
    if (e == 0 && f) return "R11";
    if (x[30:0] < 31'h00200000) return "R9";
    if (f && e >= 253) return "R10";
    if (e >= 253) return "R4";
    if (e == 0) return "R3";
    return "R2";
  endfunction

  task automatic check(input string tag, input logic [36:0] act, input logic [36:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual flags=%b result=%h expected flags=%b result=%h",
               tag, act[36:32], act[31:0], exp[36:32], exp[31:0]);
    end
  endtask

  task automatic run_op(input logic [31:0] x, input bit f, input bit d, input logic [1:0] rm);
    @(negedge clk);
    in_valid = 1'b1; operand = x; fz = f; dn = d; rmode = rm;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1", {4'b0, out_valid, 32'h0}, {4'b0, 1'b1, 32'h0});
    check(tag_of(x, f, d), {exc_flags, result}, model(x, f, d, rm));
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [36:0] held;
    void'($urandom(32'd20240611));
    #35ns;
    check("R12", {exc_flags, result}, 37'h0);
    check("R12", {36'h0, out_valid}, 37'h0);
    rst_n = 1'b1;

    // Directed corners
    run_op(32'h3F800000, 0, 0, 0);   // R2: 1.0 -> 0x3F7F8000
    check("R2", {5'b0, result}, {5'b0, 32'h3F7F8000});
    run_op(32'hC0000000, 0, 0, 3);   // R2 negative
    run_op(32'h7E800000, 0, 0, 0);   // R4 exp 253
    check("R4", {5'b0, result}, {5'b0, 32'h007FC000});
    run_op(32'h7F000000, 0, 0, 0);   // R4 exp 254
    check("R4", {5'b0, result}, {5'b0, 32'h003FE000});
    run_op(32'hFF7FFFFF, 0, 0, 1);   // R4 negative max normal
    run_op(32'h00400000, 0, 0, 0);   // R3 bit22 set
    check("R3", {5'b0, result}, {5'b0, 32'h7EFF8000});
    run_op(32'h00200000, 0, 0, 0);   // R3 bit22 clear
    check("R3", {5'b0, result}, {5'b0, 32'h7F7F8000});
    run_op(32'h807FFFFF, 0, 0, 2);   // R3
    run_op(32'h7F800001, 0, 0, 0);   // R5 signaling
    check("R5", {exc_flags, result}, {5'b10000, 32'h7FC00001});
    run_op(32'hFFC01234, 0, 0, 0);   // R5 quiet, sign kept
    run_op(32'h7F800001, 0, 1, 0);   // R6
    check("R6", {exc_flags, result}, {5'b10000, 32'h7FC00000});
    run_op(32'hFFC00000, 0, 1, 2);   // R6 quiet
    run_op(32'hFF800000, 0, 0, 0);   // R7
    check("R7", {exc_flags, result}, {5'b0, 32'h80000000});
    run_op(32'h80000000, 0, 0, 0);   // R8
    check("R8", {exc_flags, result}, {5'b01000, 32'hFF800000});
    run_op(32'h00000000, 1, 0, 3);   // R8
    run_op(32'h001FFFFF, 0, 0, 0);   // R9 just below threshold
    for (int rm = 0; rm < 4; rm++) begin
      run_op(32'h00000001, 0, 0, 2'(rm));  // R9 positive
      run_op(32'h80100000, 0, 0, 2'(rm));  // R9 negative
    end
    run_op(32'h80000001, 0, 0, 1);   // R9 up, negative -> max normal
    check("R9", {exc_flags, result}, {5'b00101, 32'hFF7FFFFF});
    run_op(32'h7E800000, 1, 0, 0);   // R10
    check("R10", {exc_flags, result}, {5'b00010, 32'h00000000});
    run_op(32'hFF000000, 1, 0, 0);   // R10 negative
    run_op(32'h7E7FFFFF, 1, 0, 0);   // R10 boundary: exp 252 not flushed
    run_op(32'h80400000, 1, 0, 0);   // R11
    check("R11", {exc_flags, result}, {5'b01000, 32'hFF800000});
    run_op(32'h00000001, 1, 0, 3);   // R11 tiny flushed

    // R1: idle cycle keeps outputs
    held = {exc_flags, result};
    @(negedge clk);
    operand = 32'h12345678;
    @(negedge clk);
    check("R1", {exc_flags, result}, held);
    check("R1", {36'h0, out_valid}, 37'h0);

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] x = $urandom;
      int pick = $urandom_range(0, 9);
      if (pick == 0) x[30:23] = 8'h00;
      if (pick == 1) x[30:23] = 8'hFF;
      if (pick == 2) x[30:23] = 8'(253 + $urandom_range(0, 1));
      if (pick == 3) x[30:21] = 10'h0;
      run_op(x, 1'($urandom), 1'($urandom), 2'($urandom));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule